// File: doc/BRIEF.md
# 8-bit Timer/Counter with Output Compare

This block is an 8-bit timer/counter with one output-compare channel. A clock-select front end picks the event that advances the counter: nothing, one of five prescaled tick strobes coming from a shared divider, or a rising or falling edge of an external clock pin. The external pin is first resynchronised into the system clock domain. The counter runs in one of three modes. In the free-running mode it counts up and wraps. In the clear-on-compare mode it counts up to a TOP taken from the compare register. In the phase-correct mode it counts up to 0xFF and back down to 0x00.

The counter value is compared with the active compare value on every timer tick. A match sets a sticky compare flag and drives a waveform output pin. A wrap or a return to zero sets a sticky overflow flag. In the two modes that use TOP or produce a symmetric waveform, the compare register is double buffered: software writes land in a buffer, and the buffer is copied to the active value when the counter is at TOP. A register write port gives software access to the counter, the compare value, the control fields and the write-one-to-clear flags.

Top module: `timer8_oc`

## Requirements
- R1: After a synchronous reset, the counter, compare readback, control readback, both flags and the waveform output are all zero, and the direction is up.
- R2: The control register holds the clock-select code. Code 000 leaves the counter frozen. Codes 001 to 101 advance it by one step on each cycle in which pre_tick[code-1] is high. All other tick lines are ignored.
- R3: Code 111 steps the counter on a rising edge of ext_clk_in and code 110 steps it on a falling edge. The pin passes through two synchronising flops and an edge detector. The counter steps at the second clock edge after the edge that first samples the new pin level. The opposite edge has no effect.
- R4: Mode 00 (and the spare mode 11) counts up and wraps from 0xFF to 0x00. The overflow flag is set by that wrap. The overflow flag is also set by the same wrap in mode 01.
- R5: In mode 01, a tick taken while the counter equals the active compare value sends the counter to 0x00. Otherwise the counter counts up.
- R6: In mode 10, the counter counts up. A tick at 0xFF reverses the direction and gives 0xFE. While counting down, a tick at 0x00 reverses the direction again and gives 0x01. The overflow flag is set by the tick that moves the counter from 0x01 to 0x00 while counting down.
- R7: In mode 00, a compare write (address 1) updates the active value at once. In modes 01 and 10 the write goes only to a buffer. The buffer is copied to the active value on a tick taken at TOP (the active value in mode 01, 0xFF in mode 10). The compare readback shows the buffer.
- R8: A tick taken while the counter equals the active compare value is a match, and the match sets the compare flag.
- R9: In modes 00, 01 and 11, a match toggles wave_o. In mode 10, a match drives wave_o to 0 while counting up and to 1 while counting down.
- R10: A counter write (address 0) loads the written value. In the same cycle it suppresses the count step, any flag event, any match and any buffer copy.
- R11: After a counter write, the first following tick produces no match.
- R12: A flag write (address 3) clears the overflow flag when bit 0 is 1 and the compare flag when bit 1 is 1. A 0 bit leaves its flag unchanged. A set event in the same cycle wins over the clear.
- R13: The control register (address 2) takes the clock-select code from bits 2:0 and the mode from bits 4:3. The other bits are ignored and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_tick | input | 5 | Prescaled tick strobes, one per clock-select code 001..101 |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 counter, 1 compare, 2 control, 3 flags |
| wr_data | input | 8 | Register write data |
| count_o | output | 8 | Current counter value |
| compare_o | output | 8 | Compare buffer readback |
| ctrl_o | output | 8 | Control readback, mode at bits 4:3, clock select at bits 2:0 |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| wave_o | output | 1 | Waveform output pin |

## Verification
If the count or the direction is wrong, count_o shows it one clock after the tick that produced it. In phase-correct mode the direction state only comes to the port at the next step, so a wrong reversal shows one tick later. If the active compare value goes stale or is copied too early, no port shows it until the counter reaches the value in question. The bench therefore runs the counter through full TOP periods after each buffered write, and it compares the flags, wave_o and count_o against a cycle-level reference model on every clock. A broken edge detector or synchroniser moves the external step by whole cycles, and the directed pin-edge sequence exposes this within three cycles.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

    localparam int NUM_PRE = 5;

    localparam logic [2:0] CS_STOP     = 3'b000;
    localparam logic [2:0] CS_EXT_FALL = 3'b110;
    localparam logic [2:0] CS_EXT_RISE = 3'b111;

    localparam int FLG_OVF = 0;
    localparam int FLG_CMP = 1;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'b00,
        MODE_CTC   = 2'b01,
        MODE_PCORR = 2'b10,
        MODE_SPARE = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ADDR_CNT  = 2'd0,
        ADDR_CMP  = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_FLAG = 2'd3
    } tmr_addr_e;

    typedef struct packed {
        tmr_mode_e  mode;
        logic [2:0] csel;
    } tmr_ctrl_t;

    function automatic logic is_buffered(input tmr_mode_e m);
        return (m == MODE_CTC) || (m == MODE_PCORR);
    endfunction

endpackage

// File: rtl/timer8_clksel.sv
module timer8_clksel
    import timer8_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         csel,
    input  logic [NUM_PRE-1:0] pre_tick,
    input  logic               ext_pin,
    output logic               tick
);

    logic sync1_q, sync2_q, prev_q;
    logic rise, fall, pre_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= ext_pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign rise = sync2_q & ~prev_q;
    assign fall = ~sync2_q & prev_q;

    always_comb begin
        pre_sel = 1'b0;
        for (int i = 0; i < NUM_PRE; i++) begin
            if (csel == 3'(i + 1)) pre_sel = pre_tick[i];
        end
    end

    always_comb begin
        case (csel)
            CS_STOP:     tick = 1'b0;
            CS_EXT_FALL: tick = fall;
            CS_EXT_RISE: tick = rise;
            default:     tick = pre_sel;
        endcase
    end

    AST_EXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);                                            // R3
    AST_EXT_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);                                            // R3

endmodule

// File: rtl/timer8_counter.sv
module timer8_counter
    import timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             ovf_evt,
    output logic             at_top
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic             step;
    logic [CNT_W-1:0] top_val, nxt_cnt;
    logic             nxt_dir;

    assign step    = tick && !cnt_wr;
    assign top_val = (mode == MODE_CTC) ? cmp_act : MAXV;
    assign at_top  = step && is_buffered(mode) && (count == top_val);

    always_comb begin
        nxt_cnt = count;
        nxt_dir = dir_down;
        ovf_evt = 1'b0;
        if (cnt_wr) begin
            nxt_cnt = cnt_wdata;
        end else if (tick) begin
            case (mode)
                MODE_PCORR: begin
                    if (!dir_down) begin
                        if (count == MAXV) begin
                            nxt_dir = 1'b1;
                            nxt_cnt = count - ONE;
                        end else begin
                            nxt_cnt = count + ONE;
                        end
                    end else if (count == '0) begin
                        nxt_dir = 1'b0;
                        nxt_cnt = count + ONE;
                    end else begin
                        nxt_cnt = count - ONE;
                        ovf_evt = (count == ONE);
                    end
                end
                MODE_CTC: begin
                    nxt_cnt = (count == cmp_act) ? '0 : count + ONE;
                    ovf_evt = (count == MAXV);
                end
                default: begin
                    nxt_cnt = count + ONE;
                    ovf_evt = (count == MAXV);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            dir_down <= 1'b0;
        end else begin
            count    <= nxt_cnt;
            dir_down <= nxt_dir;
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(count));                    // R2
    AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count == $past(cnt_wdata)));                    // R10
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && mode != MODE_PCORR && count == MAXV) |=> (count == '0)); // R4
    AST_PC_TURN: assert property (@(posedge clk) disable iff (rst)
        (step && mode == MODE_PCORR && !dir_down && count == MAXV)
        |=> (dir_down && count == MAXV - ONE));                     // R6

endmodule

// File: rtl/timer8_compare.sv
module timer8_compare
    import timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] count,
    input  logic             dir_down,
    input  logic             at_top,
    output logic [CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0] cmp_buf,
    output logic             match_evt,
    output logic             wave
);

    logic supp_q;

    assign match_evt = tick && !cnt_wr && !supp_q && (count == cmp_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act <= '0;
            cmp_buf <= '0;
            supp_q  <= 1'b0;
            wave    <= 1'b0;
        end else begin
            if (!is_buffered(mode)) begin
                if (cmp_wr) begin
                    cmp_act <= wdata;
                    cmp_buf <= wdata;
                end
            end else begin
                if (at_top) cmp_act <= cmp_buf;
                if (cmp_wr) cmp_buf <= wdata;
            end

            if (cnt_wr)    supp_q <= 1'b1;
            else if (tick) supp_q <= 1'b0;

            if (match_evt) begin
                if (mode == MODE_PCORR) wave <= dir_down;
                else                    wave <= ~wave;
            end
        end
    end

    AST_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !match_evt);                                     // R11
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (is_buffered(mode) && !at_top) |=> $stable(cmp_act));       // R7
    AST_PC_WAVE: assert property (@(posedge clk) disable iff (rst)
        (match_evt && mode == MODE_PCORR) |=> (wave == $past(dir_down))); // R9
    AST_MATCH_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (match_evt && mode != MODE_PCORR) |=> (wave != $past(wave)));     // R9

endmodule

// File: rtl/timer8_oc.sv
module timer8_oc
    import timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_PRE-1:0] pre_tick,
    input  logic               ext_clk_in,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   count_o,
    output logic [CNT_W-1:0]   compare_o,
    output logic [CNT_W-1:0]   ctrl_o,
    output logic               ovf_flag_o,
    output logic               cmp_flag_o,
    output logic               wave_o
);

    localparam int CTRL_W   = $bits(tmr_ctrl_t);
    localparam int CTRL_PAD = CNT_W - CTRL_W;

    tmr_ctrl_t        ctrl_q;
    logic             cnt_wr, cmp_wr, ctl_wr, flg_wr;
    logic             tick, ovf_evt, at_top, match_evt, dir_down;
    logic [CNT_W-1:0] count, cmp_act, cmp_buf;
    logic             ovf_q, cmpf_q;

    assign cnt_wr = wr_en && (wr_addr == ADDR_CNT);
    assign cmp_wr = wr_en && (wr_addr == ADDR_CMP);
    assign ctl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign flg_wr = wr_en && (wr_addr == ADDR_FLAG);

    timer8_clksel u_clksel (
        .clk      (clk),
        .rst      (rst),
        .csel     (ctrl_q.csel),
        .pre_tick (pre_tick),
        .ext_pin  (ext_clk_in),
        .tick     (tick)
    );

    timer8_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (ctrl_q.mode),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wr_data),
        .cmp_act   (cmp_act),
        .count     (count),
        .dir_down  (dir_down),
        .ovf_evt   (ovf_evt),
        .at_top    (at_top)
    );

    timer8_compare #(.CNT_W(CNT_W)) u_compare (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .mode      (ctrl_q.mode),
        .cnt_wr    (cnt_wr),
        .cmp_wr    (cmp_wr),
        .wdata     (wr_data),
        .count     (count),
        .dir_down  (dir_down),
        .at_top    (at_top),
        .cmp_act   (cmp_act),
        .cmp_buf   (cmp_buf),
        .match_evt (match_evt),
        .wave      (wave_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ovf_q  <= 1'b0;
            cmpf_q <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctrl_q.csel <= wr_data[2:0];
                ctrl_q.mode <= tmr_mode_e'(wr_data[4:3]);
            end
            ovf_q  <= ovf_evt   || (ovf_q  && !(flg_wr && wr_data[FLG_OVF]));
            cmpf_q <= match_evt || (cmpf_q && !(flg_wr && wr_data[FLG_CMP]));
        end
    end

    assign count_o    = count;
    assign compare_o  = cmp_buf;
    assign ctrl_o     = {{CTRL_PAD{1'b0}}, ctrl_q};
    assign ovf_flag_o = ovf_q;
    assign cmp_flag_o = cmpf_q;

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag_o);                                    // R12
    AST_CMP_SET: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> cmp_flag_o);                                  // R8
    AST_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.csel == CS_STOP && !cnt_wr) |=> $stable(count_o));  // R2

endmodule

// File: tb/timer8_oc_bench.sv
`timescale 1ns/1ps
module timer8_oc_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] pre_tick = '0;
    logic       ext_clk_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] count_o, compare_o, ctrl_o;
    logic       ovf_flag_o, cmp_flag_o, wave_o;

    int total = 0;
    int fails = 0;
    bit pin_lvl = 1'b0;

    logic [7:0] m_cnt, m_act, m_buf;
    logic [2:0] m_csel;
    logic [1:0] m_mode;
    bit m_dir, m_supp, m_wave, m_ovf, m_cmpf, m_s1, m_s2, m_prev;

    always #4 clk = ~clk;

    timer8_oc u_timer8_oc (
        .clk(clk), .rst(rst), .pre_tick(pre_tick), .ext_clk_in(ext_clk_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count_o), .compare_o(compare_o), .ctrl_o(ctrl_o),
        .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o), .wave_o(wave_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_act = 0; m_buf = 0; m_csel = 0; m_mode = 0;
        m_dir = 0; m_supp = 0; m_wave = 0; m_ovf = 0; m_cmpf = 0;
        m_s1 = 0; m_s2 = 0; m_prev = 0;
    endtask

    task automatic model_step(input bit we, input logic [1:0] a, input logic [7:0] d,
                              input logic [4:0] pt, input bit pin);
        bit tk, cw, mw, kw, fw, match, ovf_e, attop, nd;
        logic [7:0] nc, topv;
        cw = we && a == 2'd0; mw = we && a == 2'd1;
        kw = we && a == 2'd2; fw = we && a == 2'd3;
        case (m_csel)
            3'd0:    tk = 1'b0;
            3'd6:    tk = !m_s2 && m_prev;
            3'd7:    tk = m_s2 && !m_prev;
            default: tk = pt[m_csel - 3'd1];
        endcase
        match = 0; ovf_e = 0; attop = 0; nc = m_cnt; nd = m_dir;
        if (cw) nc = d;
        else if (tk) begin
            match = !m_supp && (m_cnt == m_act);
            topv  = (m_mode == 2'd1) ? m_act : 8'hFF;
            attop = (m_mode == 2'd1 || m_mode == 2'd2) && (m_cnt == topv);
            if (m_mode == 2'd2) begin
                if (!m_dir) begin
                    if (m_cnt == 8'hFF) begin nd = 1; nc = 8'hFE; end
                    else nc = m_cnt + 8'd1;
                end else if (m_cnt == 8'h00) begin nd = 0; nc = 8'h01; end
                else begin nc = m_cnt - 8'd1; ovf_e = (m_cnt == 8'h01); end
            end else begin
                nc = (m_mode == 2'd1 && m_cnt == m_act) ? 8'h00 : m_cnt + 8'd1;
                ovf_e = (m_cnt == 8'hFF);
            end
        end
        if (match) m_wave = (m_mode == 2'd2) ? m_dir : !m_wave;
        if (m_mode == 2'd0 || m_mode == 2'd3) begin
            if (mw) begin m_buf = d; m_act = d; end
        end else begin
            if (attop) m_act = m_buf;
            if (mw) m_buf = d;
        end
        m_supp = cw ? 1'b1 : (tk ? 1'b0 : m_supp);
        m_ovf  = ovf_e || (m_ovf && !(fw && d[0]));
        m_cmpf = match || (m_cmpf && !(fw && d[1]));
        m_cnt = nc; m_dir = nd;
        if (kw) begin m_csel = d[2:0]; m_mode = d[4:3]; end
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    endtask

    task automatic compare_model();
        chk("R2 count", count_o, m_cnt);
        chk("R7 compare readback", compare_o, m_buf);
        chk("R13 control readback", ctrl_o, {3'b000, m_mode, m_csel});
        chk("R4 overflow flag", ovf_flag_o, m_ovf);
        chk("R8 compare flag", cmp_flag_o, m_cmpf);
        chk("R9 wave", wave_o, m_wave);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit we, input logic [1:0] a, input logic [7:0] d,
                       input logic [4:0] pt, input bit pin);
        wr_en = we; wr_addr = a; wr_data = d; pre_tick = pt; ext_clk_in = pin;
        @(posedge clk);
        model_step(we, a, d, pt, pin);
        @(negedge clk);
        compare_model();
    endtask

    task automatic idle(input logic [4:0] pt);
        cyc(1'b0, 2'd0, 8'h00, pt, pin_lvl);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 5'h00, pin_lvl);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic w0;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 count", count_o, 0); chk("R1 compare", compare_o, 0);
        chk("R1 control", ctrl_o, 0); chk("R1 ovf", ovf_flag_o, 0);
        chk("R1 cmpf", cmp_flag_o, 0); chk("R1 wave", wave_o, 0);

        // R13 unused control bits read zero
        wreg(2'd2, 8'hFF);
        chk("R13 ctrl mask", ctrl_o, 8'h1F);
        wreg(2'd2, 8'h00);

        // R2 stopped, then selected tick line only
        repeat (4) idle(5'h1F);
        chk("R2 stopped", count_o, 8'h00);
        wreg(2'd2, 8'h03);
        repeat (3) idle(5'b00100);
        chk("R2 selected tick", count_o, 8'h03);
        repeat (3) idle(5'b11011);
        chk("R2 other ticks ignored", count_o, 8'h03);

        // R10 write beats tick, R4 wrap
        wreg(2'd2, 8'h01);
        cyc(1'b1, 2'd0, 8'hFE, 5'h01, 1'b0);
        chk("R10 write priority", count_o, 8'hFE);
        idle(5'h01);
        chk("R4 no ovf before wrap", ovf_flag_o, 0);
        idle(5'h01);
        chk("R4 wrap value", count_o, 8'h00);
        chk("R4 ovf at wrap", ovf_flag_o, 1);

        // R12 write one to clear
        cyc(1'b1, 2'd3, 8'h02, 5'h00, 1'b0);
        chk("R12 zero bit keeps ovf", ovf_flag_o, 1);
        cyc(1'b1, 2'd3, 8'h01, 5'h00, 1'b0);
        chk("R12 ovf cleared", ovf_flag_o, 0);
        cyc(1'b1, 2'd0, 8'hFF, 5'h00, 1'b0);
        cyc(1'b1, 2'd3, 8'h01, 5'h01, 1'b0);
        chk("R12 set wins over clear", ovf_flag_o, 1);

        // R5 clear on compare, R7 buffering
        wreg(2'd2, 8'h08);
        wreg(2'd1, 8'h03);
        chk("R7 readback of buffer", compare_o, 8'h03);
        wreg(2'd0, 8'h00);
        wreg(2'd3, 8'h03);
        wreg(2'd2, 8'h09);
        idle(5'h01); chk("R5 top load tick", count_o, 8'h00);
        idle(5'h01); idle(5'h01); idle(5'h01);
        chk("R5 reaches top", count_o, 8'h03);
        chk("R8 no flag before match", cmp_flag_o, 0);
        idle(5'h01);
        chk("R5 cleared at top", count_o, 8'h00);
        chk("R8 flag on match", cmp_flag_o, 1);
        cyc(1'b1, 2'd1, 8'h01, 5'h01, 1'b0);
        chk("R7 buffered readback", compare_o, 8'h01);
        idle(5'h01); idle(5'h01);
        chk("R7 old top still active", count_o, 8'h03);
        idle(5'h01); idle(5'h01); idle(5'h01);
        chk("R7 new top in effect", count_o, 8'h00);

        // R11 suppression after counter write
        wreg(2'd2, 8'h00);
        wreg(2'd1, 8'h05);
        wreg(2'd3, 8'h03);
        wreg(2'd0, 8'h05);
        wreg(2'd2, 8'h01);
        idle(5'h01);
        chk("R11 count stepped", count_o, 8'h06);
        chk("R11 match suppressed", cmp_flag_o, 0);
        w0 = wave_o;
        wreg(2'd0, 8'h04);
        idle(5'h01);
        idle(5'h01);
        chk("R8 match after suppression", cmp_flag_o, 1);
        chk("R9 toggle on match", wave_o, !w0);

        // R6 phase-correct turnarounds and R9 levels
        wreg(2'd2, 8'h10);
        wreg(2'd0, 8'hFD);
        wreg(2'd3, 8'h03);
        wreg(2'd2, 8'h11);
        idle(5'h01); idle(5'h01);
        chk("R6 reaches max", count_o, 8'hFF);
        idle(5'h01);
        chk("R6 turn at max", count_o, 8'hFE);
        idle(5'h01);
        chk("R6 counting down", count_o, 8'hFD);
        wreg(2'd0, 8'h02);
        idle(5'h01);
        chk("R6 no ovf above bottom", ovf_flag_o, 0);
        idle(5'h01);
        chk("R6 bottom", count_o, 8'h00);
        chk("R6 ovf at bottom", ovf_flag_o, 1);
        idle(5'h01);
        chk("R6 turn at bottom", count_o, 8'h01);
        repeat (5) idle(5'h01);
        chk("R9 up match clears", wave_o, 0);
        repeat (500) idle(5'h01);
        chk("R9 down position", count_o, 8'h04);
        chk("R9 down match sets", wave_o, 1);

        // R3 external edges
        wreg(2'd2, 8'h07);
        wreg(2'd0, 8'h10);
        repeat (3) idle(5'h00);
        pin_lvl = 1'b1;
        idle(5'h00); chk("R3 no step after first edge", count_o, 8'h10);
        idle(5'h00); chk("R3 no step after second edge", count_o, 8'h10);
        idle(5'h00); chk("R3 step on third edge", count_o, 8'h11);
        repeat (3) idle(5'h00);
        pin_lvl = 1'b0;
        repeat (4) idle(5'h00);
        chk("R3 falling edge ignored", count_o, 8'h11);
        wreg(2'd2, 8'h06);
        pin_lvl = 1'b1;
        repeat (4) idle(5'h00);
        chk("R3 rising edge ignored", count_o, 8'h11);
        pin_lvl = 1'b0;
        idle(5'h00); idle(5'h00);
        chk("R3 falling wait", count_o, 8'h11);
        idle(5'h00);
        chk("R3 falling step", count_o, 8'h12);

        // constrained random against the reference model
        for (int i = 0; i < 4000; i++) begin
            bit we;
            logic [7:0] d;
            we = ($urandom % 6) == 0;
            d  = 8'($urandom);
            if ($urandom % 4 == 0) pin_lvl = !pin_lvl;
            cyc(we, 2'($urandom), d, 5'($urandom), pin_lvl);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule